// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits beside a MAC receive path and decides whether an incoming frame is for this station. It watches the received byte stream that follows the start-of-frame delimiter, captures the six destination address bytes, and classifies the frame as unicast, multicast or broadcast. The destination is then compared against a 48-bit station address and passed through a 64-entry multicast hash filter. Mode controls allow promiscuous reception, and can separately disable unicast or broadcast reception.

One cycle after the sixth destination byte is taken, the block raises a decision-valid level together with an accept bit and three reason flags: station match, hash match and broadcast match. These outputs stay frozen through the rest of the frame until the next start-of-frame pulse. A frame accepted only because promiscuous mode is on carries no reason flag. Bytes after the sixth are ignored, and idle cycles between bytes are allowed.

Top module: `eth_da_filter`

## Requirements
- R1: The frame type comes from bit 0 of the first destination byte: 0 gives unicast, 1 gives multicast. A destination of 48 ones is broadcast. Multicast and broadcast never set the station flag.
- R2: A unicast frame whose six bytes equal the station address is accepted with only the station flag set. Byte k received (k = 0..5) is compared with address bits [8k+7:8k]. A mismatch in any byte rejects the frame when promiscuous mode is off.
- R3: With disable-unicast set and promiscuous mode off, a unicast frame is rejected, even on an exact station address match.
- R4: The hash index is bits [31:26] of a CRC-32 (polynomial 0x04C11DB7, MSB-first shift register, preset to all ones, no final inversion). The CRC is fed the 48 destination bits in arrival order, least significant bit of each byte first. A non-broadcast multicast frame is accepted with only the hash flag set when filter bit [index] is 1. Otherwise it is rejected, so an all-zero filter accepts no such frame.
- R5: With disable-broadcast clear, a broadcast frame is accepted with only the broadcast flag set, whatever the filter holds.
- R6: With disable-broadcast set and promiscuous mode off, a broadcast frame is accepted with only the hash flag set when its hash bit is 1, and is rejected otherwise.
- R7: In promiscuous mode every frame is accepted, and both disable controls act as if clear. A frame that matches nothing is accepted with all three flags clear.
- R8: The decision-valid level rises exactly one cycle after the sixth destination byte is taken. Until the next start-of-frame, the decision and flags hold their values, whatever further bytes arrive and however the mode and address inputs change. Idle cycles between destination bytes do not disturb the result.
- R9: A start-of-frame pulse clears the decision and all flags in the next cycle. The byte presented with it is taken as destination byte 0. A frame that stops before six destination bytes never raises decision-valid.
- R10: While rst_ni is low, decision-valid, accept and all flags are 0.
- R11: At most one reason flag is set, any set flag implies accept, and accept and the flags are 0 whenever decision-valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame pulse; marks destination byte 0 when byte_vld_i is also high |
| byte_vld_i | input | 1 | Receive byte strobe |
| byte_i | input | 8 | Received byte |
| station_addr_i | input | 48 | Station address; bits [7:0] match the first byte |
| hash_filter_i | input | 64 | Multicast hash filter, one bit per index |
| promisc_i | input | 1 | Accept every frame |
| no_ucast_i | input | 1 | Disable unicast reception |
| no_bcast_i | input | 1 | Disable broadcast reception unless the hash hits |
| dec_vld_o | output | 1 | Decision valid, held until the next start-of-frame |
| accept_o | output | 1 | Frame accepted |
| phys_match_o | output | 1 | Accepted on station address match |
| hash_match_o | output | 1 | Accepted on hash filter hit |
| bcast_match_o | output | 1 | Accepted as broadcast |

## Verification
The assertions assume that sof_i is a single-cycle pulse at most once per frame. They also assume that the mode and filter inputs hold steady in the cycle the sixth byte is taken, because the promiscuous and zero-filter checks use the values from that cycle. The stimulus keeps the modes, station address and filter fixed from start-of-frame through the sixth byte. It changes them only after the decision, to confirm that the held result ignores them. Random idle gaps are mixed into the address bytes, and short frames are followed by a full frame so that the restart path is exercised.

// File: rtl/eth_da_pkg.sv
package eth_da_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  // bit-serial CRC over one byte, LSB first
  function automatic logic [CRC_W-1:0] crc_byte(logic [CRC_W-1:0] c, logic [7:0] d);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  typedef struct packed {
    logic accept;
    logic phys;
    logic hash;
    logic bcast;
  } da_result_t;
endpackage

// File: rtl/da_byte_track.sv
module da_byte_track #(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sof_i,
  input  logic                    byte_vld_i,
  input  logic [7:0]              byte_i,
  input  logic [8*ADDR_BYTES-1:0] station_addr_i,
  output logic                    take_o,
  output logic                    last_o,
  output logic                    eq_o,
  output logic                    ones_o,
  output logic                    grp_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_b, cnt_n;
  logic eq_q, eq_b, ones_q, ones_b, grp_q, grp_b;
  logic [8*ADDR_BYTES-1:0] stn_sh;
  logic [7:0] stn_byte;

  always_comb begin
    cnt_b  = sof_i ? '0   : cnt_q;
    eq_b   = sof_i ? 1'b1 : eq_q;
    ones_b = sof_i ? 1'b1 : ones_q;
    grp_b  = sof_i ? 1'b0 : grp_q;
    stn_sh   = station_addr_i >> (8 * cnt_b);
    stn_byte = stn_sh[7:0];
    take_o = byte_vld_i && (cnt_b < CNT_W'(ADDR_BYTES));
    last_o = take_o && (cnt_b == CNT_W'(ADDR_BYTES - 1));
    cnt_n  = take_o ? cnt_b + 1'b1 : cnt_b;
    eq_o   = take_o ? (eq_b & (byte_i == stn_byte)) : eq_b;
    ones_o = take_o ? (ones_b & (&byte_i)) : ones_b;
    grp_o  = (take_o && cnt_b == '0) ? byte_i[0] : grp_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      eq_q   <= 1'b1;
      ones_q <= 1'b1;
      grp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      eq_q   <= eq_o;
      ones_q <= ones_o;
      grp_q  <= grp_o;
    end
  end
endmodule

// File: rtl/da_crc_hash.sv
module da_crc_hash
  import eth_da_pkg::*;
#(
  parameter int unsigned HASH_BITS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sof_i,
  input  logic                 take_i,
  input  logic [7:0]           byte_i,
  output logic [HASH_BITS-1:0] idx_o
);
  logic [CRC_W-1:0] crc_q, crc_b, crc_n;

  always_comb begin
    crc_b = sof_i ? '1 : crc_q;
    crc_n = take_i ? crc_byte(crc_b, byte_i) : crc_b;
    idx_o = crc_n[CRC_W-1 -: HASH_BITS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else         crc_q <= crc_n;
  end
endmodule

// File: rtl/da_decide.sv
module da_decide
  import eth_da_pkg::*;
#(
  parameter int unsigned HASH_BITS = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sof_i,
  input  logic                      last_i,
  input  logic                      eq_i,
  input  logic                      ones_i,
  input  logic                      grp_i,
  input  logic [HASH_BITS-1:0]      idx_i,
  input  logic [(1<<HASH_BITS)-1:0] hash_filter_i,
  input  logic                      promisc_i,
  input  logic                      no_ucast_i,
  input  logic                      no_bcast_i,
  output logic                      dec_vld_o,
  output da_result_t                res_o
);
  da_result_t res_d;
  logic hit, eff_no_bcast;

  always_comb begin
    hit          = hash_filter_i[idx_i];
    eff_no_bcast = no_bcast_i & ~promisc_i;  // promiscuous overrides both disables
    res_d.phys   = ~grp_i & eq_i & (~no_ucast_i | promisc_i);
    res_d.hash   = grp_i & hit & (~ones_i | eff_no_bcast);
    res_d.bcast  = ones_i & ~eff_no_bcast;
    res_d.accept = promisc_i | res_d.phys | res_d.hash | res_d.bcast;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_vld_o <= 1'b0;
      res_o     <= '0;
    end else if (last_i) begin
      dec_vld_o <= 1'b1;
      res_o     <= res_d;
    end else if (sof_i) begin
      dec_vld_o <= 1'b0;
      res_o     <= '0;
    end
  end
endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
  import eth_da_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sof_i,
  input  logic                      byte_vld_i,
  input  logic [7:0]                byte_i,
  input  logic [8*ADDR_BYTES-1:0]   station_addr_i,
  input  logic [(1<<HASH_BITS)-1:0] hash_filter_i,
  input  logic                      promisc_i,
  input  logic                      no_ucast_i,
  input  logic                      no_bcast_i,
  output logic                      dec_vld_o,
  output logic                      accept_o,
  output logic                      phys_match_o,
  output logic                      hash_match_o,
  output logic                      bcast_match_o
);
  logic take, last, eq, ones, grp;
  logic [HASH_BITS-1:0] idx;
  da_result_t res;

  da_byte_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk_i, .rst_ni, .sof_i, .byte_vld_i, .byte_i, .station_addr_i,
    .take_o(take), .last_o(last), .eq_o(eq), .ones_o(ones), .grp_o(grp)
  );

  da_crc_hash #(.HASH_BITS(HASH_BITS)) u_hash (
    .clk_i, .rst_ni, .sof_i, .take_i(take), .byte_i, .idx_o(idx)
  );

  da_decide #(.HASH_BITS(HASH_BITS)) u_decide (
    .clk_i, .rst_ni, .sof_i, .last_i(last), .eq_i(eq), .ones_i(ones), .grp_i(grp),
    .idx_i(idx), .hash_filter_i, .promisc_i, .no_ucast_i, .no_bcast_i,
    .dec_vld_o, .res_o(res)
  );

  assign accept_o      = res.accept;
  assign phys_match_o  = res.phys;
  assign hash_match_o  = res.hash;
  assign bcast_match_o = res.bcast;
endmodule

// File: rtl/eth_da_filter_chk.sv
module eth_da_filter_chk #(
  parameter int unsigned FILT_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sof_i,
  input logic [FILT_W-1:0] hash_filter_i,
  input logic              promisc_i,
  input logic              dec_vld_o,
  input logic              accept_o,
  input logic              phys_match_o,
  input logic              hash_match_o,
  input logic              bcast_match_o
);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_o && !sof_i) |=> (dec_vld_o &&
      $stable({accept_o, phys_match_o, hash_match_o, bcast_match_o})));

  a_r9_sof_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !dec_vld_o);

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_vld_o |-> !(accept_o | phys_match_o | hash_match_o | bcast_match_o));

  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({phys_match_o, hash_match_o, bcast_match_o}));

  a_r11_flag_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phys_match_o | hash_match_o | bcast_match_o) |-> accept_o);

  a_r7_promisc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dec_vld_o) && $past(promisc_i)) |-> accept_o);

  a_r4_zero_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dec_vld_o) && $past(hash_filter_i) == '0) |-> !hash_match_o);
endmodule

bind eth_da_filter eth_da_filter_chk #(.FILT_W(1 << HASH_BITS)) u_chk (.*);

// File: tb/eth_da_filter_test.sv
`timescale 1ns/1ps
module eth_da_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, vld = 1'b0;
  logic [7:0]  byt = '0;
  logic [47:0] stn = '0;
  logic [63:0] filt = '0;
  logic        pr = 1'b0, nu = 1'b0, nb = 1'b0;
  logic        dv, acc, ph, hs, bc;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  eth_da_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(byt),
    .station_addr_i(stn), .hash_filter_i(filt), .promisc_i(pr),
    .no_ucast_i(nu), .no_bcast_i(nb), .dec_vld_o(dv), .accept_o(acc),
    .phys_match_o(ph), .hash_match_o(hs), .bcast_match_o(bc)
  );

  function automatic logic [5:0] hash_idx(logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic fb = c[31] ^ da[k];
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return c[31:26];
  endfunction

  // {accept, phys, hash, bcast}
  function automatic logic [3:0] model(logic [47:0] da, logic [47:0] s, logic [63:0] f,
                                       logic p, logic u, logic b);
    logic grp = da[0], all1 = &da, hit = f[hash_idx(da)];
    logic phys, hsh, bca;
    if (all1) begin
      bca  = !b || p;
      hsh  = !bca && hit;
      phys = 1'b0;
    end else if (grp) begin
      bca = 1'b0; phys = 1'b0; hsh = hit;
    end else begin
      bca = 1'b0; hsh = 1'b0; phys = (da == s) && (!u || p);
    end
    return {p | phys | hsh | bca, phys, hsh, bca};
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {vld,acc,phys,hash,bcast} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {dv, acc, ph, hs, bc};
  endfunction

  task automatic send_da(logic [47:0] da, int gap_pct, int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      if (i > 0) begin
        while (($urandom % 100) < gap_pct) begin
          @(negedge clk); sof = 1'b0; vld = 1'b0;
        end
      end
      @(negedge clk);
      if (i == nbytes - 1 && i > 0) check("R9 no early decision", {dv, 4'b0}, 5'b0);
      sof = (i == 0); vld = 1'b1; byt = da[8*i +: 8];
    end
    @(negedge clk); sof = 1'b0; vld = 1'b0;
  endtask

  task automatic frame(string req, logic [47:0] da, int gap_pct);
    logic [3:0] e = model(da, stn, filt, pr, nu, nb);
    logic [4:0] got;
    send_da(da, gap_pct, 6);
    got = outs();
    check(req, got, {1'b1, e});
    // payload bytes and input changes must not disturb the held result (R8)
    for (int j = 0; j < 3; j++) begin
      vld = $urandom % 2; byt = 8'($urandom);
      pr = $urandom % 2; nu = $urandom % 2; nb = $urandom % 2;
      @(negedge clk);
    end
    vld = 1'b0;
    check("R8 hold", outs(), got);
  endtask

  logic [47:0] bcast_da = '1;

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R10 reset", outs(), 5'b0);
    rst_n = 1'b1;
    stn = 48'h5A4B_3C2D_1E0E;  // bit 0 of byte 0 clear

    frame("R2 station match", stn, 0);
    frame("R2 last byte mismatch", stn ^ 48'h0100_0000_0000, 0);
    frame("R2 first byte mismatch", stn ^ 48'h0000_0000_0002, 30);
    nu = 1'b1; frame("R3 unicast disabled", stn, 0);
    nu = 1'b1; pr = 1'b1; frame("R7 promisc overrides unicast disable", stn, 0);
    pr = 1'b1; nu = 1'b0; frame("R7 promisc no match no flags", 48'h1111_2222_3344, 0);
    pr = 1'b0; filt = '0;
    frame("R4 zero filter rejects multicast", 48'h0000_5E00_0001, 0);
    filt = 64'h1 << hash_idx(48'h0000_5E00_0001);
    frame("R4 hash hit", 48'h0000_5E00_0001, 20);
    filt = '0; nb = 1'b0; frame("R5 broadcast accepted", bcast_da, 0);
    filt = 64'h1 << hash_idx(bcast_da); nb = 1'b0;
    frame("R5 broadcast flag only despite hash", bcast_da, 0);
    nb = 1'b1; frame("R6 broadcast disabled hash hit", bcast_da, 0);
    nb = 1'b1; filt = ~filt; frame("R6 broadcast disabled hash miss", bcast_da, 0);
    nb = 1'b1; pr = 1'b1; frame("R7 promisc overrides broadcast disable", bcast_da, 0);
    pr = 1'b0; nb = 1'b0; filt = '1;
    frame("R1 group bit set is multicast", stn | 48'h1, 0);

    // R9 short frame then restart
    send_da(48'h0123_4567_89AB, 0, 3);
    repeat (4) @(negedge clk);
    check("R9 short frame no decision", outs(), 5'b0);
    frame("R9 full frame after short", stn, 0);

    for (int n = 0; n < 300; n++) begin
      logic [47:0] da;
      int sel = $urandom % 4;
      pr = ($urandom % 5) == 0; nu = $urandom % 2; nb = $urandom % 2;
      filt = ($urandom % 4 == 0) ? 64'h0 : {$urandom, $urandom};
      da = {$urandom, $urandom};
      case (sel)
        0: da = stn;
        1: da = '1;
        2: da[0] = 1'b1;
        default: da[0] = 1'b0;
      endcase
      frame("R1-model random frame", da, 25);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule